// File: doc/BRIEF.md
# Two-Thread Context-Aware Cache Tag Lookup

This block holds the tag, valid and owner state of a small set-associative data cache. The cache is indexed and tagged by linear address and is shared by two hardware threads. Each cycle it answers one lookup with hit, hit way and victim way. Each cycle it can also install one line from a fill request. The data array, miss tracking and coherence live elsewhere. The byte offset is stripped upstream, so both address ports carry a line address: the low bits select the set and the high bits form the tag.

A run-time policy bit chooses how the two threads see each other's lines. In the shared policy every line belongs to both threads and a tag match is enough to hit. This allows a linear address to alias across threads. In the adaptive policy the block compares the two threads' page-table base values and paging-mode codes. While both pairs are equal, the threads share lines as in the shared policy. When either differs, the block isolates the threads: each line carries the ID of the thread that filled it, and only that thread may hit on it. Capacity is then divided by ordinary competition. A compile-time variant also confines each thread to its own half of the ways while it is isolated.

Policy and context changes apply from the next lookup on. No flush is needed, because every fill records its owner whatever the policy was at the time.

Top module: `tcx_tag_lookup`

## Requirements
- R1: After reset every lookup misses, and `lk_victim` is 0 in every set.
- R2: With `cfg_adaptive`=0, `lk_hit` is 1 exactly when `lk_valid` is 1 and a valid line in set `lk_addr[3:0]` holds tag `lk_addr[11:4]`, whatever `lk_tid` and the line's owner are. `lk_hit_way` gives the lowest-numbered such way.
- R3: `ctx_share` is 1 exactly when `ptb_t0`==`ptb_t1` and `pmode_t0`==`pmode_t1`.
- R4: With `cfg_adaptive`=1 and `ctx_share`=1 the R2 rule applies, so either thread hits on lines filled by the other.
- R5: With `cfg_adaptive`=1 and `ctx_share`=0 (isolated), a hit also needs the line's owner to equal `lk_tid`. The same tag can then be held twice in a set, once per thread.
- R6: On a clock edge with `fill_en`=1 and `flush`=0, the fill request is judged under the current rules. If it hits, that way is rewritten; otherwise the victim way is written. The line becomes valid with tag `fill_addr[11:4]` and owner `fill_tid`, in every policy, and it is visible to lookups from the next cycle on.
- R7: The victim is the lowest-numbered invalid way that the requesting thread may use. If there is none, the victim is the set's round-robin pointer.
- R8: After a fill into way w, that set's pointer becomes (w+1) mod 4. The pointers of other sets do not change.
- R9: `flush`=1 clears every valid bit at the next edge and discards a fill requested in the same cycle.
- R10: A change of policy bit or context is seen by the very next lookup, and lines installed earlier are kept and hit again when the rules allow it.
- R11: With `SPLIT`=1 and the threads isolated, thread t may hit and allocate only in ways 2t and 2t+1. When both are valid, the victim is 2t + (pointer mod 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all lines |
| cfg_adaptive | input | 1 | 0 = shared policy, 1 = adaptive policy |
| ptb_t0 | input | PTB_W | Page-table base of thread 0 |
| ptb_t1 | input | PTB_W | Page-table base of thread 1 |
| pmode_t0 | input | PMODE_W | Paging-mode code of thread 0 |
| pmode_t1 | input | PMODE_W | Paging-mode code of thread 1 |
| lk_valid | input | 1 | Lookup request present |
| lk_tid | input | 1 | Thread issuing the lookup |
| lk_addr | input | TAG_W+log2(SETS) | Lookup line address {tag, set} |
| fill_en | input | 1 | Install a line this cycle |
| fill_tid | input | 1 | Thread owning the fill |
| fill_addr | input | TAG_W+log2(SETS) | Fill line address {tag, set} |
| lk_hit | output | 1 | Lookup hit |
| lk_hit_way | output | log2(WAYS) | Way that hit (0 on a miss) |
| lk_victim | output | log2(WAYS) | Way a fill for this lookup would take |
| ctx_share | output | 1 | The two thread contexts match |

## Verification
The hardest situation to reach is a line installed under one sharing rule and then looked up under another. Examples are a line filled by one thread while shared, then probed by the other thread after the contexts diverge, or a rewrite on a shared hit that moves ownership. A directed sequence builds these cases step by step without flushing, and a checking model runs beside both the owner-bit and the split variants. A long pseudo-random sweep then changes policy bit, base values and mode codes on every cycle. It keeps the addresses to a handful of tags in a few sets, so that conflicts, evictions and duplicate per-thread copies occur often.

// File: rtl/tcx_pkg.sv
package tcx_pkg;

    typedef enum logic {
        POL_SHARED   = 1'b0,
        POL_ADAPTIVE = 1'b1
    } policy_e;

    // Qualification carried with each request into the way selector.
    typedef struct packed {
        logic isolate;   // threads must not see each other's lines
        logic tid;       // requesting thread
    } qual_t;

    // Index of the lowest set bit, 0 when none is set.
    function automatic int unsigned first_one(input logic [63:0] vec);
        int unsigned pos;
        pos = 0;
        for (int i = 63; i >= 0; i--) begin
            if (vec[i]) pos = unsigned'(i);
        end
        return pos;
    endfunction

endpackage

// File: rtl/tcx_ctx_cmp.sv
module tcx_ctx_cmp #(
    parameter int PTB_W   = 20,
    parameter int PMODE_W = 2
) (
    input  logic [PTB_W-1:0]   ptb_a,
    input  logic [PTB_W-1:0]   ptb_b,
    input  logic [PMODE_W-1:0] pmode_a,
    input  logic [PMODE_W-1:0] pmode_b,
    output logic               same
);
    assign same = (ptb_a == ptb_b) && (pmode_a == pmode_b);
endmodule

// File: rtl/tcx_way_select.sv
module tcx_way_select
    import tcx_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int TAG_W = 8,
    parameter int SPLIT = 0
) (
    input  logic                            req_valid,
    input  qual_t                           qual,
    input  logic [TAG_W-1:0]                req_tag,
    input  logic [WAYS-1:0]                 row_valid,
    input  logic [WAYS-1:0]                 row_owner,
    input  logic [WAYS-1:0][TAG_W-1:0]      row_tag,
    input  logic [$clog2(WAYS)-1:0]         row_rr,
    output logic                            hit,
    output logic [$clog2(WAYS)-1:0]         hit_way,
    output logic [$clog2(WAYS)-1:0]         victim
);
    localparam int WAY_W = $clog2(WAYS);
    localparam int HALF  = WAYS / 2;

    logic [WAYS-1:0] allow;
    logic [WAYS-1:0] match;
    logic [WAYS-1:0] free;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        localparam logic UPPER = (w >= HALF);
        assign allow[w] = !((SPLIT != 0) && qual.isolate) || (UPPER == qual.tid);
        assign match[w] = row_valid[w] && (row_tag[w] == req_tag)
                        && (!qual.isolate || (row_owner[w] == qual.tid))
                        && allow[w];
        assign free[w]  = allow[w] && !row_valid[w];
    end

    always_comb begin
        hit     = req_valid && (|match);
        hit_way = (|match) ? WAY_W'(first_one(64'(match))) : '0;
        if (|free) begin
            victim = WAY_W'(first_one(64'(free)));
        end else if ((SPLIT != 0) && qual.isolate) begin
            victim = WAY_W'(qual.tid ? HALF : 0) + WAY_W'(int'(row_rr) % HALF);
        end else begin
            victim = row_rr;
        end
    end
endmodule

// File: rtl/tcx_tag_store.sv
module tcx_tag_store #(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int TAG_W = 8,
    parameter int NRD   = 2
) (
    input  logic                                          clk,
    input  logic                                          rst,
    input  logic                                          flush,
    input  logic                                          wr_en,
    input  logic [$clog2(SETS)-1:0]                       wr_idx,
    input  logic [$clog2(WAYS)-1:0]                       wr_way,
    input  logic [TAG_W-1:0]                              wr_tag,
    input  logic                                          wr_owner,
    input  logic [NRD-1:0][$clog2(SETS)-1:0]              rd_idx,
    output logic [NRD-1:0][WAYS-1:0]                      rd_valid,
    output logic [NRD-1:0][WAYS-1:0]                      rd_owner,
    output logic [NRD-1:0][WAYS-1:0][TAG_W-1:0]           rd_tag,
    output logic [NRD-1:0][$clog2(WAYS)-1:0]              rd_rr
);
    localparam int WAY_W = $clog2(WAYS);

    logic [SETS-1:0][WAYS-1:0]             vld_q;
    logic [SETS-1:0][WAYS-1:0]             own_q;
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
    logic [SETS-1:0][WAY_W-1:0]            rr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            own_q <= '0;
            tag_q <= '0;
            rr_q  <= '0;
        end else if (flush) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx][wr_way] <= 1'b1;
            own_q[wr_idx][wr_way] <= wr_owner;
            tag_q[wr_idx][wr_way] <= wr_tag;
            rr_q[wr_idx]          <= wr_way + WAY_W'(1);
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_valid[p] = vld_q[rd_idx[p]];
        assign rd_owner[p] = own_q[rd_idx[p]];
        assign rd_tag[p]   = tag_q[rd_idx[p]];
        assign rd_rr[p]    = rr_q[rd_idx[p]];
    end
endmodule

// File: rtl/tcx_tag_lookup.sv
module tcx_tag_lookup
    import tcx_pkg::*;
#(
    parameter int SETS    = 16,
    parameter int WAYS    = 4,
    parameter int TAG_W   = 8,
    parameter int PTB_W   = 20,
    parameter int PMODE_W = 2,
    parameter int SPLIT   = 0
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 flush,
    input  logic                                 cfg_adaptive,
    input  logic [PTB_W-1:0]                     ptb_t0,
    input  logic [PTB_W-1:0]                     ptb_t1,
    input  logic [PMODE_W-1:0]                   pmode_t0,
    input  logic [PMODE_W-1:0]                   pmode_t1,
    input  logic                                 lk_valid,
    input  logic                                 lk_tid,
    input  logic [TAG_W+$clog2(SETS)-1:0]        lk_addr,
    input  logic                                 fill_en,
    input  logic                                 fill_tid,
    input  logic [TAG_W+$clog2(SETS)-1:0]        fill_addr,
    output logic                                 lk_hit,
    output logic [$clog2(WAYS)-1:0]              lk_hit_way,
    output logic [$clog2(WAYS)-1:0]              lk_victim,
    output logic                                 ctx_share
);
    localparam int IDX_W   = $clog2(SETS);
    localparam int WAY_W   = $clog2(WAYS);
    localparam int LINE_W  = TAG_W + IDX_W;
    localparam int NRD     = 2;
    localparam int P_LK    = 0;
    localparam int P_FILL  = 1;

    logic                                 isolate;
    logic [NRD-1:0]                       req_valid;
    logic [NRD-1:0]                       req_tid;
    logic [NRD-1:0][LINE_W-1:0]           req_addr;
    logic [NRD-1:0][IDX_W-1:0]            rd_idx;
    logic [NRD-1:0][WAYS-1:0]             rd_valid;
    logic [NRD-1:0][WAYS-1:0]             rd_owner;
    logic [NRD-1:0][WAYS-1:0][TAG_W-1:0]  rd_tag;
    logic [NRD-1:0][WAY_W-1:0]            rd_rr;
    qual_t [NRD-1:0]                      rd_qual;
    logic [NRD-1:0]                       sel_hit;
    logic [NRD-1:0][WAY_W-1:0]            sel_way;
    logic [NRD-1:0][WAY_W-1:0]            sel_vic;
    logic [WAY_W-1:0]                     wr_way;

    tcx_ctx_cmp #(.PTB_W(PTB_W), .PMODE_W(PMODE_W)) u_ctx (
        .ptb_a   (ptb_t0),
        .ptb_b   (ptb_t1),
        .pmode_a (pmode_t0),
        .pmode_b (pmode_t1),
        .same    (ctx_share)
    );

    assign isolate = (policy_e'(cfg_adaptive) == POL_ADAPTIVE) && !ctx_share;

    assign req_valid[P_LK]   = lk_valid;
    assign req_tid[P_LK]     = lk_tid;
    assign req_addr[P_LK]    = lk_addr;
    assign req_valid[P_FILL] = fill_en;
    assign req_tid[P_FILL]   = fill_tid;
    assign req_addr[P_FILL]  = fill_addr;

    for (genvar p = 0; p < NRD; p++) begin : g_port
        assign rd_idx[p]          = req_addr[p][IDX_W-1:0];
        assign rd_qual[p].isolate = isolate;
        assign rd_qual[p].tid     = req_tid[p];

        tcx_way_select #(.WAYS(WAYS), .TAG_W(TAG_W), .SPLIT(SPLIT)) u_sel (
            .req_valid (req_valid[p]),
            .qual      (rd_qual[p]),
            .req_tag   (req_addr[p][LINE_W-1:IDX_W]),
            .row_valid (rd_valid[p]),
            .row_owner (rd_owner[p]),
            .row_tag   (rd_tag[p]),
            .row_rr    (rd_rr[p]),
            .hit       (sel_hit[p]),
            .hit_way   (sel_way[p]),
            .victim    (sel_vic[p])
        );
    end

    // A fill that already hits rewrites its own line, so no duplicate forms.
    assign wr_way = sel_hit[P_FILL] ? sel_way[P_FILL] : sel_vic[P_FILL];

    tcx_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .NRD(NRD)) u_store (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .wr_en    (fill_en),
        .wr_idx   (rd_idx[P_FILL]),
        .wr_way   (wr_way),
        .wr_tag   (fill_addr[LINE_W-1:IDX_W]),
        .wr_owner (fill_tid),
        .rd_idx   (rd_idx),
        .rd_valid (rd_valid),
        .rd_owner (rd_owner),
        .rd_tag   (rd_tag),
        .rd_rr    (rd_rr)
    );

    assign lk_hit     = sel_hit[P_LK];
    assign lk_hit_way = sel_way[P_LK];
    assign lk_victim  = sel_vic[P_LK];
endmodule

// File: rtl/tcx_tag_lookup_chk.sv
module tcx_tag_lookup_chk #(
    parameter int WAYS   = 4,
    parameter int LINE_W = 12,
    parameter int SPLIT  = 0
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      flush,
    input logic                      cfg_adaptive,
    input logic                      ctx_share,
    input logic                      lk_valid,
    input logic                      lk_tid,
    input logic [LINE_W-1:0]         lk_addr,
    input logic                      lk_hit,
    input logic [$clog2(WAYS)-1:0]   lk_hit_way,
    input logic [$clog2(WAYS)-1:0]   lk_victim,
    input logic                      fill_en,
    input logic                      fill_tid,
    input logic [LINE_W-1:0]         fill_addr,
    input logic [WAYS-1:0]           lk_row_valid,
    input logic [WAYS-1:0]           lk_row_owner
);
    logic isolate;
    assign isolate = cfg_adaptive && !ctx_share;

    // R1: nothing is cached right after reset
    p_reset_empty_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && lk_valid) |-> !lk_hit);

    p_reset_victim_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lk_victim == '0));

    // R5: an isolated hit always lands on a line of the requesting thread
    p_no_cross_hit_r5: assert property (@(posedge clk) disable iff (rst)
        (lk_hit && isolate) |-> (lk_row_owner[lk_hit_way] == lk_tid));

    // R6: the filling thread sees its line on the next cycle
    p_fill_visible_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(fill_en) && !$past(flush) && lk_valid
         && (lk_tid == $past(fill_tid)) && (lk_addr == $past(fill_addr))
         && ((SPLIT == 0) || ($past(isolate) == isolate))) |-> lk_hit);

    // R7: a free way is always preferred over eviction
    p_victim_free_r7: assert property (@(posedge clk) disable iff (rst)
        (!isolate && !(&lk_row_valid)) |-> !lk_row_valid[lk_victim]);

    // R9: a flush empties the cache for the following cycle
    p_flush_empties_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(flush) && lk_valid) |-> !lk_hit);

    if (SPLIT != 0) begin : g_split
        localparam int HALF = WAYS / 2;
        // R11: isolated threads stay inside their own half
        p_split_hit_r11: assert property (@(posedge clk) disable iff (rst)
            (lk_hit && isolate) |-> ((lk_hit_way >= HALF) == lk_tid));
        p_split_victim_r11: assert property (@(posedge clk) disable iff (rst)
            isolate |-> ((lk_victim >= HALF) == lk_tid));
    end
endmodule

bind tcx_tag_lookup tcx_tag_lookup_chk #(
    .WAYS   (WAYS),
    .LINE_W (LINE_W),
    .SPLIT  (SPLIT)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .flush        (flush),
    .cfg_adaptive (cfg_adaptive),
    .ctx_share    (ctx_share),
    .lk_valid     (lk_valid),
    .lk_tid       (lk_tid),
    .lk_addr      (lk_addr),
    .lk_hit       (lk_hit),
    .lk_hit_way   (lk_hit_way),
    .lk_victim    (lk_victim),
    .fill_en      (fill_en),
    .fill_tid     (fill_tid),
    .fill_addr    (fill_addr),
    .lk_row_valid (rd_valid[0]),
    .lk_row_owner (rd_owner[0])
);

// File: tb/tcx_tag_lookup_tb.sv
`timescale 1ns/1ps
module tcx_tag_lookup_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        cfg = 1'b0;
    logic [19:0] ptb0 = 20'h100;
    logic [19:0] ptb1 = 20'h100;
    logic [1:0]  pm0 = 2'd0;
    logic [1:0]  pm1 = 2'd0;
    logic        lkv = 1'b1;
    logic        lkt = 1'b0;
    logic [11:0] lka = '0;
    logic        fe = 1'b0;
    logic        ft = 1'b0;
    logic [11:0] fa = '0;

    logic       hit [2];
    logic [1:0] hway [2];
    logic [1:0] vic [2];
    logic       cs [2];

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    // reference state per variant: 0 = owner bit, 1 = static split
    bit         mv [2][16][4];
    logic [7:0] mt [2][16][4];
    bit         mo [2][16][4];
    int         mr [2][16];

    always #2.5 clk = ~clk;

    tcx_tag_lookup u_dut (
        .clk(clk), .rst(rst), .flush(flush), .cfg_adaptive(cfg),
        .ptb_t0(ptb0), .ptb_t1(ptb1), .pmode_t0(pm0), .pmode_t1(pm1),
        .lk_valid(lkv), .lk_tid(lkt), .lk_addr(lka),
        .fill_en(fe), .fill_tid(ft), .fill_addr(fa),
        .lk_hit(hit[0]), .lk_hit_way(hway[0]), .lk_victim(vic[0]), .ctx_share(cs[0])
    );

    tcx_tag_lookup #(.SPLIT(1)) u_dut_split (
        .clk(clk), .rst(rst), .flush(flush), .cfg_adaptive(cfg),
        .ptb_t0(ptb0), .ptb_t1(ptb1), .pmode_t0(pm0), .pmode_t1(pm1),
        .lk_valid(lkv), .lk_tid(lkt), .lk_addr(lka),
        .fill_en(fe), .fill_tid(ft), .fill_addr(fa),
        .lk_hit(hit[1]), .lk_hit_way(hway[1]), .lk_victim(vic[1]), .ctx_share(cs[1])
    );

    function automatic logic [11:0] la(input int tg, input int st);
        return {8'(tg), 4'(st)};
    endfunction

    function automatic bit iso_now();
        return cfg && !((ptb0 == ptb1) && (pm0 == pm1));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic mlook(input int v, input bit tid, input logic [11:0] a, input bit iso,
                         output bit h, output int hw, output int vc);
        int  st;
        bit  al;
        st = int'(a[3:0]);
        h = 0; hw = 0; vc = -1;
        for (int w = 0; w < 4; w++) begin
            al = !(v == 1 && iso) || ((w >= 2) == tid);
            if (!h && al && mv[v][st][w] && mt[v][st][w] == a[11:4] && (!iso || mo[v][st][w] == tid)) begin
                h = 1; hw = w;
            end
            if (vc < 0 && al && !mv[v][st][w]) vc = w;
        end
        if (vc < 0) vc = (v == 1 && iso) ? (int'(tid) * 2 + mr[v][st] % 2) : mr[v][st];
    endtask

    task automatic mfill(input bit tid, input logic [11:0] a, input bit iso);
        bit h; int hw; int vc; int w; int st;
        st = int'(a[3:0]);
        for (int v = 0; v < 2; v++) begin
            mlook(v, tid, a, iso, h, hw, vc);
            w = h ? hw : vc;
            mv[v][st][w] = 1;
            mt[v][st][w] = a[11:4];
            mo[v][st][w] = tid;
            mr[v][st] = (w + 1) % 4;
        end
    endtask

    // one clock with optional flush / fill; called at posedge+1
    task automatic cyc(input bit fl, input bit en, input bit tid, input logic [11:0] a);
        flush = fl; fe = en; ft = tid; fa = a;
        if (fl) begin
            for (int v = 0; v < 2; v++)
                for (int s = 0; s < 16; s++)
                    for (int w = 0; w < 4; w++) mv[v][s][w] = 0;
        end else if (en) begin
            mfill(tid, a, iso_now());
        end
        @(posedge clk); #1;
        flush = 0; fe = 0;
    endtask

    // directed lookup with hand-computed expectations
    task automatic look(input int v, input bit tid, input logic [11:0] a,
                        input bit eh, input int ew, input string req);
        lkv = 1; lkt = tid; lka = a;
        #0.5;
        chk(req, 32'(hit[v]), 32'(eh));
        if (eh) chk(req, 32'(hway[v]), 32'(ew));
    endtask

    task automatic vchk(input int v, input bit tid, input logic [11:0] a, input int ev, input string req);
        lkt = tid; lka = a;
        #0.5;
        chk(req, 32'(vic[v]), 32'(ev));
    endtask

    task automatic model_cmp();
        bit h; int hw; int vc; bit iso; string rq;
        iso = iso_now();
        #0.5;
        chk("R3", 32'(cs[0]), 32'((ptb0 == ptb1) && (pm0 == pm1)));
        for (int v = 0; v < 2; v++) begin
            mlook(v, lkt, lka, iso, h, hw, vc);
            rq = (v == 1 && iso) ? "R11" : (iso ? "R5" : (cfg ? "R4" : "R2"));
            chk(rq, 32'(hit[v]), 32'(lkv && h));
            if (lkv && h) chk(rq, 32'(hway[v]), 32'(hw));
            chk("R7", 32'(vic[v]), 32'(vc));
        end
    endtask

    logic [31:0] rs = 32'h1234_5678;
    function automatic logic [31:0] nxt(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 reset state
        look(0, 0, la(3, 1), 0, 0, "R1");
        look(1, 0, la(3, 1), 0, 0, "R1");
        vchk(0, 0, la(3, 1), 0, "R1");
        vchk(0, 1, la(9, 12), 0, "R1");
        chk("R3", 32'(cs[0]), 32'd1);

        // shared policy with mismatching contexts
        ptb1 = 20'h200; #0.5;
        chk("R3", 32'(cs[0]), 32'd0);
        cyc(0, 1, 0, la(8'h11, 1));
        look(0, 1, la(8'h11, 1), 1, 0, "R2");
        look(1, 1, la(8'h11, 1), 1, 0, "R2");
        look(0, 0, la(8'h12, 1), 0, 0, "R2");
        lkv = 0; #0.5;
        chk("R2", 32'(hit[0]), 32'd0);
        lkv = 1;

        // adaptive, isolated, no flush in between
        cfg = 1;
        look(0, 1, la(8'h11, 1), 0, 0, "R5");
        look(0, 0, la(8'h11, 1), 1, 0, "R10");
        cyc(0, 1, 1, la(8'h11, 1));
        look(0, 1, la(8'h11, 1), 1, 1, "R5");
        look(1, 1, la(8'h11, 1), 1, 2, "R11");
        look(0, 0, la(8'h11, 1), 1, 0, "R5");
        look(1, 0, la(8'h11, 1), 1, 0, "R11");

        // context compare
        ptb1 = 20'h100; pm1 = 2'd1; #0.5;
        chk("R3", 32'(cs[0]), 32'd0);
        pm1 = 2'd0; #0.5;
        chk("R3", 32'(cs[0]), 32'd1);
        look(0, 1, la(8'h11, 1), 1, 0, "R4");
        look(1, 1, la(8'h11, 1), 1, 0, "R4");

        // fill hit rewrites the owner
        cyc(0, 1, 1, la(8'h11, 1));
        ptb1 = 20'h200;
        look(0, 0, la(8'h11, 1), 0, 0, "R6");
        look(0, 1, la(8'h11, 1), 1, 0, "R6");
        look(1, 0, la(8'h11, 1), 0, 0, "R6");
        look(1, 1, la(8'h11, 1), 1, 2, "R11");
        cfg = 0;
        look(0, 0, la(8'h11, 1), 1, 0, "R10");

        // victim order and round-robin pointer in set 2
        for (int i = 0; i < 4; i++) cyc(0, 1, 0, la(8'h21 + i, 2));
        look(0, 0, la(8'h24, 2), 1, 3, "R7");
        vchk(0, 0, la(8'h25, 2), 0, "R8");
        cyc(0, 1, 0, la(8'h25, 2));
        vchk(0, 0, la(8'h25, 2), 1, "R8");
        look(0, 0, la(8'h21, 2), 0, 0, "R8");
        look(0, 1, la(8'h22, 2), 1, 1, "R2");
        vchk(0, 0, la(8'h25, 3), 0, "R8");
        cyc(0, 1, 0, la(8'h22, 2));
        vchk(0, 0, la(8'h26, 2), 2, "R8");

        // flush beats a fill in the same cycle
        cyc(1, 1, 0, la(8'h30, 4));
        look(0, 0, la(8'h30, 4), 0, 0, "R9");
        look(0, 0, la(8'h22, 2), 0, 0, "R9");
        look(0, 0, la(8'h11, 1), 0, 0, "R9");
        vchk(0, 0, la(8'h22, 2), 0, "R9");

        // static split under isolation, set 7
        cfg = 1; ptb1 = 20'h200;
        cyc(0, 1, 1, la(8'h41, 7));
        cyc(0, 1, 0, la(8'h42, 7));
        cyc(0, 1, 1, la(8'h43, 7));
        look(1, 1, la(8'h43, 7), 1, 3, "R11");
        look(0, 1, la(8'h43, 7), 1, 2, "R5");
        cyc(0, 1, 1, la(8'h44, 7));
        look(0, 1, la(8'h44, 7), 1, 3, "R7");
        look(1, 1, la(8'h44, 7), 1, 2, "R11");
        look(1, 1, la(8'h41, 7), 0, 0, "R11");
        look(0, 1, la(8'h41, 7), 1, 0, "R5");
        look(1, 0, la(8'h42, 7), 1, 0, "R11");

        // sweep: policy and context move every cycle, few tags and sets
        for (int i = 0; i < 6000; i++) begin
            rs = nxt(rs);
            cfg  = rs[0];
            ptb1 = rs[1] ? ptb0 : (ptb0 ^ 20'h1);
            pm1  = (rs[2] | rs[25]) ? pm0 : 2'd3;
            lkv  = rs[3] | rs[4];
            lkt  = rs[5];
            lka  = la(int'(rs[8:6]), rs[9] ? int'(rs[13:10]) : int'(rs[11:10]));
            model_cmp();
            if (rs[19:14] == 6'd0)
                cyc(1, rs[20], rs[21], la(int'(rs[24:22]), int'(rs[27:26])));
            else if (rs[16:14] != 3'd0)
                cyc(0, 1, rs[21], la(int'(rs[24:22]), rs[28] ? int'(rs[31:28]) : int'(rs[27:26])));
            else
                cyc(0, 0, 0, '0);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule